// File: doc/BRIEF.md
# Dual-Width Byte-Lane Memory Core

This block is a clocked static memory that holds an array of 16-bit words. It can be accessed as a 16-bit word memory or as an 8-bit byte memory, and a mode input chooses which. The controls are two chip selects (one active-low, one active-high), a low-lane enable, a high-lane enable, a write strobe and an output drive strobe. Every control is sampled on the rising clock edge and decoded into one of four operations: standby, write, read or output-off. The bidirectional data pins are split into an input bus, an output bus and one output-enable bit per byte lane.

In byte mode only bits 7:0 carry data. Input bit 15 becomes the least-significant address bit: 0 selects the lower half of the addressed word and 1 selects the upper half. A write does not happen while its strobes are held. It is committed on the clock edge at which the sampled overlap of the active strobes ends, using the address, data and lanes from the last active sample. A read has one cycle of latency. The memory is written so that block RAM can be inferred.

Top module: `dwsram_core`

## Requirements
- R1: The block is selected only when `ce_n` is 0 and `ce` is 1. When it is not selected, nothing is written and `lane_oe` is 00 in the cycle after that sample.
- R2: In word mode (`wide_mode`=1), holding both `lane_lo_n` and `lane_hi_n` at 1 is standby: nothing is written and no lane is driven.
- R3: In word mode, the lanes are gated independently: `lane_lo_n`=0 enables bits 7:0 (`lane_oe[0]`) and `lane_hi_n`=0 enables bits 15:8 (`lane_oe[1]`), for both reads and writes.
- R4: When selected with `we_n`=0, the enabled lanes are written, `drv_n` has no effect, and `lane_oe` is 00 in the following cycle.
- R5: When selected with `we_n`=1 and `drv_n`=0, the stored data of the enabled lanes appears on `dout`, and the matching `lane_oe` bits are set, one cycle after the sample.
- R6: When selected with `we_n`=1 and `drv_n`=1, `lane_oe` is 00 and the memory is unchanged.
- R7: In byte mode (`wide_mode`=0, both lane enables 0), `din[15]` is the low address bit (0 selects word bits 7:0, 1 selects word bits 15:8). Data moves on bits 7:0 only, and `lane_oe[1]` stays 0.
- R8: A write is committed on the first clock edge at which the sampled write overlap is inactive. It uses the address, data and lanes of the last active sample. When an overlap spans several addresses, only the last one is written.
- R9: In byte mode, a selected access with either lane enable at 1 raises `mode_err` one cycle later and is treated as standby: nothing is written and no lane is driven.
- R10: Any lane whose `lane_oe` bit is 0 reads as zero on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip select |
| ce | input | 1 | Active-high chip select |
| wide_mode | input | 1 | 1 = 16-bit word mode, 0 = 8-bit byte mode |
| lane_lo_n | input | 1 | Active-low enable for bits 7:0 |
| lane_hi_n | input | 1 | Active-low enable for bits 15:8 |
| we_n | input | 1 | Active-low write strobe |
| drv_n | input | 1 | Active-low output drive strobe |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data; bit 15 is the low address bit in byte mode |
| dout | output | 16 | Read data, zero on lanes that are not driven |
| lane_oe | output | 2 | Per-lane output enable (bit 0 = low lane) |
| mode_err | output | 1 | Byte-mode access made with a lane enable high |

## Verification
The bench holds a write overlap active across two different addresses. A design that commits every active cycle, instead of only when the overlap ends, would corrupt the first address. Byte-mode traffic covers both halves of a word, so a swapped or ignored `din[15]` shows up as data in the wrong half or as an overwritten neighbour byte. Single-lane word writes catch a mask that spills into the other lane. Writes made while deselected, with both lanes off, or in byte mode with a bad lane setting must all leave the memory untouched; a decoder that lets any of these through would change the read-back.

// File: rtl/dwsram_pkg.sv
package dwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_ODIS  = 2'd3
  } op_e;
endpackage

// File: rtl/dwsram_decode.sv
module dwsram_decode
  import dwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              ce_n,
  input  logic              ce,
  input  logic              wide_mode,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic              we_n,
  input  logic              drv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output op_e               op,
  output logic [1:0]        lanes,
  output logic [ADDR_W-1:0] word_addr,
  output logic [WORD_W-1:0] wdata,
  output logic              half,
  output logic              bad_mode
);
  logic selected;

  assign selected  = !ce_n && ce;
  assign half      = din[WORD_W-1];
  assign word_addr = addr;
  assign wdata     = wide_mode ? din : {2{din[LANE_W-1:0]}};

  always_comb begin
    lanes    = 2'b00;
    bad_mode = 1'b0;
    if (wide_mode) begin
      lanes = {!lane_hi_n, !lane_lo_n};
    end else if (!lane_lo_n && !lane_hi_n) begin
      lanes = half ? 2'b10 : 2'b01;
    end else begin
      bad_mode = selected;
    end
    op = OP_IDLE;
    if (selected && lanes != 2'b00) begin
      if (!we_n)       op = OP_WRITE;
      else if (!drv_n) op = OP_READ;
      else             op = OP_ODIS;
    end
  end

  // R7: a byte-mode access touches exactly one half of the word
  always_comb begin
    if (op != OP_IDLE && !wide_mode)
      a_r7_byte_one_lane: assert ($onehot(lanes));
  end
endmodule

// File: rtl/dwsram_wtrack.sv
module dwsram_wtrack #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [1:0]        lanes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic              commit,
  output logic [1:0]        c_lanes,
  output logic [ADDR_W-1:0] c_addr,
  output logic [WORD_W-1:0] c_data
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      c_lanes <= '0;
      c_addr  <= '0;
      c_data  <= '0;
    end else begin
      act_q <= active;
      if (active) begin
        c_lanes <= lanes;
        c_addr  <= addr;
        c_data  <= data;
      end
    end
  end

  assign commit = act_q && !active;
endmodule

// File: rtl/dwsram_array.sv
module dwsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  parameter int NLANE  = 2,
  localparam int WORD_W = NLANE * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [NLANE-1:0]  we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NLANE; i++) begin
      if (we[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dwsram_core.sv
module dwsram_core
  import dwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  localparam int NLANE  = 2,
  localparam int WORD_W = NLANE * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              wide_mode,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic              we_n,
  input  logic              drv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic [NLANE-1:0]  lane_oe,
  output logic              mode_err
);
  op_e               op;
  logic [1:0]        lanes;
  logic [ADDR_W-1:0] word_addr;
  logic [WORD_W-1:0] wdata;
  logic              half;
  logic              bad_mode;
  logic              commit;
  logic [1:0]        c_lanes;
  logic [ADDR_W-1:0] c_addr;
  logic [WORD_W-1:0] c_data;
  logic [WORD_W-1:0] rdata;
  logic              narrow_q;
  logic              half_q;

  dwsram_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_decode (
    .ce_n(ce_n), .ce(ce), .wide_mode(wide_mode), .lane_lo_n(lane_lo_n),
    .lane_hi_n(lane_hi_n), .we_n(we_n), .drv_n(drv_n), .addr(addr), .din(din),
    .op(op), .lanes(lanes), .word_addr(word_addr), .wdata(wdata), .half(half),
    .bad_mode(bad_mode)
  );

  dwsram_wtrack #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wtrack (
    .clk(clk), .rst(rst), .active(op == OP_WRITE), .lanes(lanes),
    .addr(word_addr), .data(wdata), .commit(commit), .c_lanes(c_lanes),
    .c_addr(c_addr), .c_data(c_data)
  );

  dwsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NLANE(NLANE)) u_array (
    .clk(clk), .we(commit ? c_lanes : 2'b00), .waddr(c_addr), .wdata(c_data),
    .re(op == OP_READ), .raddr(word_addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_oe  <= '0;
      mode_err <= 1'b0;
      narrow_q <= 1'b0;
      half_q   <= 1'b0;
    end else begin
      mode_err <= bad_mode;
      if (op == OP_READ) begin
        lane_oe  <= wide_mode ? lanes : 2'b01;
        narrow_q <= !wide_mode;
        half_q   <= half;
      end else begin
        lane_oe <= '0;
      end
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] lane_val;
    if (g == 0) begin : g_low
      assign lane_val = (narrow_q && half_q) ? rdata[LANE_W +: LANE_W] : rdata[0 +: LANE_W];
    end else begin : g_other
      assign lane_val = rdata[g*LANE_W +: LANE_W];
    end
    assign dout[g*LANE_W +: LANE_W] = lane_oe[g] ? lane_val : '0;
  end

  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (rst)
    (ce_n || !ce) |=> (lane_oe == 2'b00));
  a_r4_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && ce && !we_n) |=> (lane_oe == 2'b00));
  a_r6_odis_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && ce && we_n && drv_n) |=> (lane_oe == 2'b00));
  a_r7_upper_quiet: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |=> !lane_oe[1]);
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> (lane_oe == 2'b00));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (lane_oe == 2'b00) |-> (dout == '0));
endmodule

// File: tb/test_dwsram_core.sv
module test_dwsram_core;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst, ce_n, ce, wide_mode, lane_lo_n, lane_hi_n, we_n, drv_n;
  logic [ADDR_W-1:0] addr;
  logic [15:0] din, dout;
  logic [1:0]  lane_oe;
  logic        mode_err;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] sh [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  dwsram_core #(.ADDR_W(ADDR_W), .LANE_W(8)) i_dwsram_core (
    .clk(clk), .rst(rst), .ce_n(ce_n), .ce(ce), .wide_mode(wide_mode),
    .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .we_n(we_n), .drv_n(drv_n),
    .addr(addr), .din(din), .dout(dout), .lane_oe(lane_oe), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic cen, input logic c, input logic wide, input logic lo,
                       input logic hi, input logic we, input logic dr,
                       input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_n = cen; ce = c; wide_mode = wide; lane_lo_n = lo; lane_hi_n = hi;
    we_n = we; drv_n = dr; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(1, 0, 1, 1, 1, 1, 1, '0, '0);
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] ln);
    return {ln[1] ? d[15:8] : old[15:8], ln[0] ? d[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] exp_word(input logic [ADDR_W-1:0] a, input logic [1:0] ln);
    return {ln[1] ? sh[a][15:8] : 8'h00, ln[0] ? sh[a][7:0] : 8'h00};
  endfunction

  task automatic wword(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic [1:0] ln);
    drive(0, 1, 1, !ln[0], !ln[1], 0, 1, a, d);
    drive(0, 1, 1, !ln[0], !ln[1], 0, 1, a, d);
    idle();
    sh[a] = merge(sh[a], d, ln);
  endtask

  task automatic wbyte(input logic [ADDR_W:0] ba, input logic [7:0] b);
    drive(0, 1, 0, 0, 0, 0, 1, ba[ADDR_W:1], {ba[0], 7'h00, b});
    drive(0, 1, 0, 0, 0, 0, 1, ba[ADDR_W:1], {ba[0], 7'h00, b});
    idle();
    sh[ba[ADDR_W:1]] = merge(sh[ba[ADDR_W:1]], {b, b}, ba[0] ? 2'b10 : 2'b01);
  endtask

  task automatic rword(input logic [ADDR_W-1:0] a, input logic [1:0] ln, input string tag);
    drive(0, 1, 1, !ln[0], !ln[1], 1, 0, a, '0);
    chk(dout == exp_word(a, ln), {tag, " dout"}, dout, exp_word(a, ln));
    chk(lane_oe == ln, {tag, " lane_oe"}, lane_oe, ln);
  endtask

  task automatic rbyte(input logic [ADDR_W:0] ba, input string tag);
    logic [15:0] e;
    drive(0, 1, 0, 0, 0, 1, 0, ba[ADDR_W:1], {ba[0], 15'h0});
    e = {8'h00, ba[0] ? sh[ba[ADDR_W:1]][15:8] : sh[ba[ADDR_W:1]][7:0]};
    chk(dout == e, {tag, " dout"}, dout, e);
    chk(lane_oe == 2'b01, {tag, " lane_oe"}, lane_oe, 2'b01);
  endtask

  initial begin
    #(CLK_P * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; ce_n = 1; ce = 0; wide_mode = 1; lane_lo_n = 1; lane_hi_n = 1;
    we_n = 1; drv_n = 1; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(lane_oe == 2'b00 && dout == 16'h0 && mode_err == 1'b0, "reset state", {lane_oe, mode_err, dout}, 0);
    @(negedge clk);
    rst = 0;

    for (int i = 0; i < DEPTH; i++) wword(i[ADDR_W-1:0], $urandom, 2'b11);

    // R5 / R3: full and single lane reads
    rword(8'h10, 2'b11, "R5 word read");
    rword(8'h11, 2'b01, "R3 low lane read");
    rword(8'h12, 2'b10, "R3 high lane read");
    // R3: single lane writes leave the other lane untouched
    wword(8'h20, 16'hABCD, 2'b01);
    rword(8'h20, 2'b11, "R3 low lane write");
    wword(8'h21, 16'h1234, 2'b10);
    rword(8'h21, 2'b11, "R3 high lane write");

    // R1: deselected writes and reads
    drive(1, 1, 1, 0, 0, 0, 1, 8'h30, 16'hDEAD); idle();
    drive(0, 0, 1, 0, 0, 0, 1, 8'h30, 16'hBEEF); idle();
    rword(8'h30, 2'b11, "R1 deselected write ignored");
    drive(1, 1, 1, 0, 0, 1, 0, 8'h30, '0);
    chk(lane_oe == 2'b00 && dout == 16'h0, "R1 deselected read quiet / R10", {lane_oe, dout}, 0);

    // R2: both lanes off in word mode
    drive(0, 1, 1, 1, 1, 0, 1, 8'h31, 16'h5A5A); idle();
    rword(8'h31, 2'b11, "R2 no-lane write ignored");
    drive(0, 1, 1, 1, 1, 1, 0, 8'h31, '0);
    chk(lane_oe == 2'b00, "R2 no-lane read quiet", lane_oe, 0);

    // R4: write with drive strobe low does not drive
    drive(0, 1, 1, 0, 0, 0, 0, 8'h32, 16'hC3C3);
    chk(lane_oe == 2'b00 && dout == 16'h0, "R4 write not driven", {lane_oe, dout}, 0);
    idle();
    sh[8'h32] = 16'hC3C3;
    rword(8'h32, 2'b11, "R4 write stored");

    // R6: output-off
    drive(0, 1, 1, 0, 0, 1, 1, 8'h32, 16'hFFFF);
    chk(lane_oe == 2'b00 && dout == 16'h0, "R6 output off / R10", {lane_oe, dout}, 0);
    idle();
    rword(8'h32, 2'b11, "R6 memory unchanged");

    // R7: byte mode both halves
    wbyte({8'h40, 1'b0}, 8'h11);
    wbyte({8'h40, 1'b1}, 8'h99);
    rword(8'h40, 2'b11, "R7 byte halves in word");
    rbyte({8'h40, 1'b1}, "R7 upper half byte read");
    rbyte({8'h40, 1'b0}, "R7 lower half byte read");

    // R8: overlap spanning two addresses commits only the last
    drive(0, 1, 1, 0, 0, 0, 1, 8'h50, 16'h1111);
    drive(0, 1, 1, 0, 0, 0, 1, 8'h51, 16'h2222);
    idle();
    sh[8'h51] = 16'h2222;
    rword(8'h50, 2'b11, "R8 earlier overlap address untouched");
    rword(8'h51, 2'b11, "R8 last overlap address written");

    // R9: bad byte-mode lanes
    drive(0, 1, 0, 0, 1, 1, 0, 8'h40, '0);
    chk(mode_err == 1'b1 && lane_oe == 2'b00, "R9 error flagged, quiet", {mode_err, lane_oe}, 3'b100);
    drive(0, 1, 0, 1, 0, 0, 1, 8'h40, 16'h00EE); idle();
    chk(mode_err == 1'b0, "R9 error clears", mode_err, 0);
    rword(8'h40, 2'b11, "R9 bad byte write ignored");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] ln;
      ln = 2'($urandom_range(1, 3));
      case ($urandom % 4)
        0: wword(ADDR_W'($urandom), 16'($urandom), ln);
        1: wbyte((ADDR_W+1)'($urandom), 8'($urandom));
        2: rword(ADDR_W'($urandom), ln, "R3 R5 random word read");
        default: rbyte((ADDR_W+1)'($urandom), "R7 random byte read");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule